// File: doc/BRIEF.md
# BCD-Programmed Synthesizer Divider Chain

This block is the digital division chain of a channelised frequency synthesizer. Two dividers sit in one clock domain and each sees its input clock as a clock enable. The reference divider counts enables from a crystal oscillator and emits one comparison pulse every 2^REF_SHIFT enables (1024 at the default setting), or twice that many when the step-halving select is high. A 10.24 MHz crystal therefore yields a 10 kHz comparison rate, or 5 kHz with the select high.

The programmable divider counts enables from the mixed-down oscillator signal. It emits one pulse every N enables, where N is a three-digit decimal channel number given as packed BCD on ten parallel inputs. Both pulse trains feed a phase detector. When the loop is locked, each step of one in the channel number moves the oscillator by one comparison-rate step. A new channel number, or a new reference ratio, is adopted only at the divider's own terminal count, so the period that is in progress is never cut short. A channel word that contains a non-decimal digit is flagged and ignored.

Each divider is a small state machine. The reference divider has the states RD_BASE (ratio 2^REF_SHIFT) and RD_DOUBLE (ratio 2^(REF_SHIFT+1)). At a reference terminal count it moves RD_BASE→RD_DOUBLE when the select is high and RD_DOUBLE→RD_BASE when the select is low; otherwise it stays where it is. The programmable divider has the states PD_BYPASS (modulus 0 or 1, every enable is terminal) and PD_COUNT (modulus 2 to 399). At each terminal count it loads the decoded word if that word is valid. It then goes to PD_BYPASS when the loaded modulus is at most 1 and to PD_COUNT otherwise. Reset enters RD_BASE and PD_BYPASS.

Top module: `synth_div_chain`

## Requirements
- R1: chan_bcd[9:8] holds the hundreds digit, chan_bcd[7:4] the tens digit and chan_bcd[3:0] the units digit. For a value N = 100·hundreds + 10·tens + units in the range 2 to 399, osc_pulse occurs once every N osc_tick enables.
- R2: Channel values 0 and 1 both select divide-by-1, so osc_pulse is high in the cycle after every cycle in which osc_tick is high.
- R3: Each pulse lasts one clock cycle. It is registered, and goes high in the cycle after the enable that completes a period.
- R4: code_bad is high in the same cycle whenever the tens or units digit of chan_bcd exceeds 9. While code_bad is high the word is not loaded, and the previous division ratio continues.
- R5: A new channel word is taken only at the programmable divider's terminal count. A period in progress completes with the old modulus.
- R6: ref_pulse occurs once every 2^REF_SHIFT xtal_tick enables when step_half is low, and once every 2^(REF_SHIFT+1) enables when step_half is high.
- R7: A change of step_half takes effect at the next reference terminal count. The reference period in progress keeps its ratio.
- R8: While reset is low both pulse outputs are low. After reset the reference divider starts in the base ratio, and the programmable divider starts in bypass, so the first osc_tick produces a pulse and loads the channel word.
- R9: A pulse never appears unless its divider's enable was high in the preceding cycle.
- R10: Channel values that differ by one give periods that differ by exactly one osc_tick enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for both dividers |
| rst_n | input | 1 | Active-low synchronous reset |
| xtal_tick | input | 1 | Crystal clock enable, one count per high cycle |
| osc_tick | input | 1 | Mixed-down oscillator enable, one count per high cycle |
| chan_bcd | input | 10 | Packed BCD channel number: hundreds [9:8], tens [7:4], units [3:0] |
| step_half | input | 1 | High selects the doubled reference ratio |
| ref_pulse | output | 1 | One-cycle reference comparison pulse |
| osc_pulse | output | 1 | One-cycle divided oscillator pulse |
| code_bad | output | 1 | High while chan_bcd holds a non-decimal digit |

## Verification
The assertions assume that both enables and all control inputs are settled before each rising clock edge, and that REF_SHIFT is at least 1, so that two reference pulses can never be adjacent. The period-window checks in the checker count enables from the release of reset and need nothing else from the stimulus. The bench uses REF_SHIFT = 3, so that ratio changes come up often. It drives every input a short delay after the rising edge and samples the outputs on the falling edge. It changes the channel word and the select only at chosen points relative to observed pulses, which makes it possible to predict which period the change applies to.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

    localparam int BCD_W   = 10;
    localparam int MOD_W   = 9;
    localparam int MOD_MAX = 399;

    typedef enum logic {
        RD_BASE,
        RD_DOUBLE
    } ref_state_t;

    typedef enum logic {
        PD_BYPASS,
        PD_COUNT
    } prog_state_t;

endpackage

// File: rtl/synth_bcd_decode.sv
module synth_bcd_decode
    import synth_div_pkg::*;
(
    input  logic [BCD_W-1:0] code_i,
    output logic [MOD_W-1:0] value_o,
    output logic             bad_o
);

    logic [1:0] hund;
    logic [3:0] tens;
    logic [3:0] unit;

    assign hund = code_i[9:8];
    assign tens = code_i[7:4];
    assign unit = code_i[3:0];

    assign bad_o   = (tens > 4'd9) || (unit > 4'd9);
    assign value_o = MOD_W'(hund) * MOD_W'(100)
                   + MOD_W'(tens) * MOD_W'(10)
                   + MOD_W'(unit);

endmodule

// File: rtl/synth_ref_divider.sv
module synth_ref_divider
    import synth_div_pkg::*;
#(
    parameter int REF_SHIFT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic wide_i,
    output logic pulse_o
);

    localparam int CNT_W = REF_SHIFT + 1;
    localparam logic [CNT_W-1:0] LAST_BASE   = CNT_W'((1 << REF_SHIFT) - 1);
    localparam logic [CNT_W-1:0] LAST_DOUBLE = '1;

    ref_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             terminal;

    always_comb begin
        state_d  = state_q;
        terminal = 1'b0;
        unique case (state_q)
            RD_BASE: begin
                terminal = tick_i && (cnt_q == LAST_BASE);
                if (terminal && wide_i) state_d = RD_DOUBLE;
            end
            RD_DOUBLE: begin
                terminal = tick_i && (cnt_q == LAST_DOUBLE);
                if (terminal && !wide_i) state_d = RD_BASE;
            end
        endcase
        if (terminal)    cnt_d = '0;
        else if (tick_i) cnt_d = cnt_q + 1'b1;
        else             cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_BASE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pulse_o <= 1'b0;
        else        pulse_o <= terminal;
    end

endmodule

// File: rtl/synth_prog_divider.sv
module synth_prog_divider
    import synth_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [MOD_W-1:0] value_i,
    input  logic             valid_i,
    output logic             pulse_o
);

    prog_state_t      state_q, state_d;
    logic [MOD_W-1:0] mod_q, mod_d;
    logic [MOD_W-1:0] cnt_q, cnt_d;
    logic [MOD_W-1:0] take;
    logic             terminal;

    always_comb begin
        state_d  = state_q;
        mod_d    = mod_q;
        cnt_d    = cnt_q;
        terminal = 1'b0;
        take     = valid_i ? value_i : mod_q;
        unique case (state_q)
            PD_BYPASS: terminal = tick_i;
            PD_COUNT:  terminal = tick_i && (cnt_q == mod_q - MOD_W'(1));
        endcase
        if (terminal) begin
            cnt_d   = '0;
            mod_d   = take;
            state_d = (take <= MOD_W'(1)) ? PD_BYPASS : PD_COUNT;
        end else if (tick_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PD_BYPASS;
            mod_q   <= MOD_W'(1);
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            mod_q   <= mod_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pulse_o <= 1'b0;
        else        pulse_o <= terminal;
    end

endmodule

// File: rtl/synth_div_chain.sv
module synth_div_chain
    import synth_div_pkg::*;
#(
    parameter int REF_SHIFT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xtal_tick,
    input  logic             osc_tick,
    input  logic [BCD_W-1:0] chan_bcd,
    input  logic             step_half,
    output logic             ref_pulse,
    output logic             osc_pulse,
    output logic             code_bad
);

    logic [MOD_W-1:0] chan_value;

    synth_bcd_decode u_decode (
        .code_i  (chan_bcd),
        .value_o (chan_value),
        .bad_o   (code_bad)
    );

    synth_ref_divider #(
        .REF_SHIFT (REF_SHIFT)
    ) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (xtal_tick),
        .wide_i  (step_half),
        .pulse_o (ref_pulse)
    );

    synth_prog_divider u_prog (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (osc_tick),
        .value_i (chan_value),
        .valid_i (!code_bad),
        .pulse_o (osc_pulse)
    );

endmodule

// File: rtl/synth_div_chain_chk.sv
module synth_div_chain_chk #(
    parameter int REF_SHIFT = 10
) (
    input logic clk,
    input logic rst_n,
    input logic xtal_tick,
    input logic osc_tick,
    input logic ref_pulse,
    input logic osc_pulse
);

    localparam int BASE    = 1 << REF_SHIFT;
    localparam int GAP_W   = REF_SHIFT + 3;
    localparam int OSC_W   = 10;
    localparam int OSC_TOP = 399;

    logic [GAP_W-1:0] ref_gap;
    logic [OSC_W-1:0] osc_gap;

    always_ff @(posedge clk) begin
        if (!rst_n)                          ref_gap <= '0;
        else if (ref_pulse)                  ref_gap <= GAP_W'(xtal_tick);
        else if (xtal_tick && ref_gap != '1) ref_gap <= ref_gap + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                         osc_gap <= '0;
        else if (osc_pulse)                 osc_gap <= OSC_W'(osc_tick);
        else if (osc_tick && osc_gap != '1) osc_gap <= osc_gap + 1'b1;
    end

    // R6
    ref_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |-> (ref_gap >= GAP_W'(BASE)) && (ref_gap <= GAP_W'(2 * BASE)));

    // R1
    osc_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        osc_pulse |-> (osc_gap >= OSC_W'(1)) && (osc_gap <= OSC_W'(OSC_TOP)));

    // R3
    ref_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |=> !ref_pulse);

    // R9
    ref_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |-> $past(xtal_tick));

    // R9
    osc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        osc_pulse |-> $past(osc_tick));

endmodule

bind synth_div_chain synth_div_chain_chk #(.REF_SHIFT(REF_SHIFT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xtal_tick (xtal_tick),
    .osc_tick  (osc_tick),
    .ref_pulse (ref_pulse),
    .osc_pulse (osc_pulse)
);

// File: tb/tb_synth_div_chain.sv
module tb_synth_div_chain;

    localparam int SHIFT = 3;
    localparam int BASE  = 1 << SHIFT;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xtal_tick = 1'b0;
    logic       osc_tick = 1'b0;
    logic [9:0] chan_bcd = '0;
    logic       step_half = 1'b0;
    logic       ref_pulse, osc_pulse, code_bad;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int xtal_mode = 0;
    int osc_mode  = 0;

    always #4 clk = ~clk;

    synth_div_chain #(.REF_SHIFT(SHIFT)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .xtal_tick (xtal_tick),
        .osc_tick  (osc_tick),
        .chan_bcd  (chan_bcd),
        .step_half (step_half),
        .ref_pulse (ref_pulse),
        .osc_pulse (osc_pulse),
        .code_bad  (code_bad)
    );

    function automatic logic gate(int m, int c);
        case (m)
            1:       return 1'b1;
            2:       return (c % 3) == 0;
            default: return 1'b0;
        endcase
    endfunction

    initial forever begin
        @(posedge clk);
        #1;
        xtal_tick = gate(xtal_mode, cyc);
        osc_tick  = gate(osc_mode, cyc);
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial forever begin
        @(posedge clk);
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic osc_wait();
        do @(negedge clk); while (!osc_pulse);
    endtask

    task automatic osc_count(output int n);
        n = 0;
        do begin
            if (osc_tick) n++;
            @(negedge clk);
        end while (!osc_pulse);
    endtask

    task automatic osc_period(output int n);
        osc_wait();
        osc_count(n);
    endtask

    task automatic ref_wait();
        do @(negedge clk); while (!ref_pulse);
    endtask

    task automatic ref_count(output int n);
        n = 0;
        do begin
            if (xtal_tick) n++;
            @(negedge clk);
        end while (!ref_pulse);
    endtask

    function automatic logic [9:0] to_bcd(int v);
        return {2'((v / 100) % 4), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    function automatic int expect_mod(int v);
        return (v < 2) ? 1 : v;
    endfunction

    initial begin
        int n;
        int prev_n;
        logic prev_tick;

        // R8: reset state
        repeat (3) begin
            @(negedge clk);
            check(ref_pulse == 1'b0 && osc_pulse == 1'b0, "R8 reset pulses", int'(ref_pulse) + int'(osc_pulse), 0);
        end
        rst_n = 1'b1;
        chan_bcd = to_bcd(5);
        xtal_mode = 1;

        // R8: first reference period after reset uses the base ratio
        n = 0;
        do begin
            if (xtal_tick) n++;
            @(negedge clk);
        end while (!ref_pulse);
        check(n == BASE, "R8 first ref period", n, BASE);
        @(negedge clk);
        check(ref_pulse == 1'b0, "R3 ref pulse width", int'(ref_pulse), 0);

        // R8: first oscillator enable pulses at once (bypass)
        osc_mode = 1;
        n = 0;
        do begin
            if (osc_tick) n++;
            @(negedge clk);
        end while (!osc_pulse);
        check(n == 1, "R8 first osc enable", n, 1);
        osc_count(n);
        check(n == 5, "R1 modulus 5", n, 5);

        // R6: reference ratios under two enable patterns
        ref_period(n);
        check(n == BASE, "R6 base ratio", n, BASE);
        xtal_mode = 2;
        ref_period(n);
        check(n == BASE, "R6 base ratio gated", n, BASE);
        xtal_mode = 1;

        // R7: select change waits for the terminal count
        ref_wait();
        step_half = 1'b1;
        ref_count(n);
        check(n == BASE, "R7 period in progress", n, BASE);
        ref_count(n);
        check(n == 2 * BASE, "R6 doubled ratio", n, 2 * BASE);
        step_half = 1'b0;
        ref_count(n);
        check(n == 2 * BASE, "R7 period in progress back", n, 2 * BASE);
        ref_count(n);
        check(n == BASE, "R6 base ratio restored", n, BASE);

        // R1 R2 R10: sweep 0..99
        prev_n = 0;
        for (int v = 0; v < 100; v++) begin
            chan_bcd = to_bcd(v);
            osc_period(n);
            check(n == expect_mod(v), (v < 2) ? "R2 divide-by-1" : "R1 sweep", n, expect_mod(v));
            if (v >= 3) check(n - prev_n == 1, "R10 unit step", n - prev_n, 1);
            prev_n = n;
        end

        // R1: hundreds digits 1..3
        for (int v = 100; v <= 399; v += 13) begin
            chan_bcd = to_bcd(v);
            osc_period(n);
            check(n == v, "R1 sweep hundreds", n, v);
        end
        chan_bcd = 10'b11_1001_1001;
        osc_period(n);
        check(n == 399, "R1 top code", n, 399);

        // R1: gated enables
        osc_mode = 2;
        chan_bcd = 10'b10_0100_0101;
        osc_period(n);
        check(n == 245, "R1 gated 245", n, 245);
        chan_bcd = to_bcd(1);
        osc_period(n);
        check(n == 1, "R2 gated code 1", n, 1);
        // R2 R3: pulse follows each enable by one cycle
        for (int k = 0; k < 30; k++) begin
            prev_tick = osc_tick;
            @(negedge clk);
            check(osc_pulse == prev_tick, "R2 pulse follows enable", int'(osc_pulse), int'(prev_tick));
        end
        osc_mode = 1;

        // R4: invalid words are flagged and ignored
        chan_bcd = to_bcd(37);
        #1;
        check(code_bad == 1'b0, "R4 valid flag", int'(code_bad), 0);
        osc_period(n);
        check(n == 37, "R4 baseline", n, 37);
        chan_bcd = {2'd1, 4'd12, 4'd3};
        #1;
        check(code_bad == 1'b1, "R4 bad tens flag", int'(code_bad), 1);
        osc_period(n);
        check(n == 37, "R4 bad tens kept", n, 37);
        chan_bcd = {2'd3, 4'd4, 4'd10};
        #1;
        check(code_bad == 1'b1, "R4 bad units flag", int'(code_bad), 1);
        osc_period(n);
        check(n == 37, "R4 bad units kept", n, 37);

        // R5: mid-period change completes old period
        chan_bcd = to_bcd(200);
        osc_period(n);
        check(n == 200, "R5 setup", n, 200);
        n = 0;
        repeat (50) begin
            if (osc_tick) n++;
            @(negedge clk);
        end
        chan_bcd = to_bcd(30);
        do begin
            if (osc_tick) n++;
            @(negedge clk);
        end while (!osc_pulse);
        check(n == 200, "R5 period in progress", n, 200);
        osc_count(n);
        check(n == 30, "R5 new modulus", n, 30);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    task automatic ref_period(output int n);
        ref_wait();
        ref_count(n);
    endtask

endmodule